// File: doc/BRIEF.md
# Ping-Pong Loop Burst Sequencer

This block is the slave-side framing and turnaround engine of a half-duplex, two-wire digital subscriber loop. A demodulator recovers bits from the master's burst and presents them one at a time. The block collects ten of them into one word: eight voice bits followed by two signaling bits. When the tenth bit arrives, it strobes the word out and raises a one-cycle burst-done pulse. That pulse is the frame sync for the slave, because there is no local frame counter. The codec clock sequencer uses the same pulse.

The burst-done pulse also starts the slave's reply. In the next cycle the block begins to send its own ten-bit word at the line bit rate. While it sends, the modulator enable is high. At all other times the enable is low, so the line rests at its idle reference.

The reply word comes from the codec through a one-entry valid/ready holding stage. In loopback, the reply is the word just received, so the link can be tested in a working system. If the demodulator reports carrier loss part-way through a burst, the partial burst is thrown away.

Top module: `loop_burst_seq`

## Requirements
- R1: After reset, mod_en, line_bit, burst_done and rx_word_valid are 0, and codec_ready is 1.
- R2: Each accepted rx_bit (rx_bit_valid high) is shifted in. The first eight bits of a burst form rx_voice, MSB first. The last two form rx_sig, with the ninth bit in rx_sig[1]. In the cycle after the tenth bit is accepted, rx_word_valid and burst_done are high for exactly one cycle, and rx_voice/rx_sig hold the new word. rx_word_valid is a strobe and cannot be back-pressured.
- R3: rx_abort drops any partly collected burst. An abort in the same cycle as a bit drops that bit as well. A dropped burst produces no burst_done, no rx_word_valid and no transmission, and the next bit starts a fresh burst.
- R4: mod_en rises in the cycle after burst_done and stays high for exactly 10 × TICKS_PER_BIT cycles. It is low at every other time.
- R5: While mod_en is high, line_bit carries the reply word in this order: voice MSB first, then sig[1], then sig[0]. Each bit is held for TICKS_PER_BIT cycles. line_bit is 0 whenever mod_en is low.
- R6: codec_ready is high exactly when no codec word is held. A word is taken on a cycle with codec_valid and codec_ready both high. A word offered while codec_ready is low is not taken. A held word is used by the next non-loopback reply, and codec_ready returns high in the cycle after that reply starts.
- R7: If no codec word is held when a non-loopback reply starts, the reply word is all zeros.
- R8: With loopback high when a reply starts, the reply is the word just received. A held codec word is kept for a later reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line reference clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| loopback | input | 1 | Reply with the received word instead of codec data |
| rx_bit_valid | input | 1 | A recovered line bit is present |
| rx_bit | input | 1 | Recovered line bit |
| rx_abort | input | 1 | Carrier lost; drop the partial burst |
| codec_valid | input | 1 | Codec reply word offered |
| codec_ready | output | 1 | Holding stage is empty |
| codec_voice | input | VOICE_W | Codec reply voice bits |
| codec_sig | input | SIG_W | Codec reply signaling bits |
| rx_word_valid | output | 1 | Received word strobe |
| rx_voice | output | VOICE_W | Received voice bits |
| rx_sig | output | SIG_W | Received signaling bits |
| burst_done | output | 1 | One-cycle frame sync pulse at the end of the master burst |
| mod_en | output | 1 | Modulator enable during the slave's reply |
| line_bit | output | 1 | Serial reply bit to the modulator |

## Verification
The bench builds the block with VOICE_W=8 and SIG_W=2, the real frame, and with TICKS_PER_BIT=4 instead of 16. The shorter bit period makes each burst exchange short enough that all 1024 received words can be swept, each paired with a different codec reply that is checked bit by bit on the line. With the same short timing, 64 loopback frames fit in the run, along with aborts at several points inside a burst and the empty and full states of the holding stage.

// File: rtl/loop_pkg.sv
package loop_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/loop_rx_deser.sv
module loop_rx_deser #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              abort_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        cnt_q <= '0;
      end else if (bit_valid_i) begin
        sh_q <= {sh_q[WORD_W-2:0], bit_i};
        if (cnt_q == LAST) begin
          word_q <= {sh_q[WORD_W-2:0], bit_i};
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;

  // R3: an abort never yields a completion in the following cycle
  assert_abort_no_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !done_o);
  // R2: completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/loop_tx_hold.sv
module loop_tx_hold #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              launch_i,
  input  logic              loopback_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [WORD_W-1:0] word_o
);
  logic              full_q;
  logic [WORD_W-1:0] hold_q;
  logic              take;
  logic              use_hold;

  assign take     = in_valid && !full_q;
  assign use_hold = launch_i && !loopback_i && full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        hold_q <= in_word;
      end else if (use_hold) begin
        full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (loopback_i)  word_o = rx_word_i;
    else if (full_q) word_o = hold_q;
    else             word_o = '0;
  end

  assign in_ready = !full_q;

  // R6: an accepted word closes the stage on the next cycle
  assert_full_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R8: a loopback reply leaves a held codec word in place
  assert_keep_in_loopback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && loopback_i && !in_ready) |=> !in_ready);
endmodule

// File: rtl/loop_tx_ser.sv
module loop_tx_ser
  import loop_pkg::*;
#(
  parameter int WORD_W        = 10,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              line_o
);
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam int IW = $clog2(WORD_W);
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);
  localparam logic [IW-1:0] LAST_BIT  = IW'(WORD_W - 1);

  tx_state_e         state_q;
  logic [TW-1:0]     tick_q;
  logic [IW-1:0]     idx_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      tick_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (launch_i) begin
            state_q <= TX_SEND;
            sh_q    <= word_i;
            tick_q  <= '0;
            idx_q   <= '0;
          end
        end
        default: begin
          if (tick_q == LAST_TICK) begin
            tick_q <= '0;
            if (idx_q == LAST_BIT) begin
              state_q <= TX_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            end
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q == TX_SEND);
  assign line_o = busy_o & sh_q[WORD_W-1];

  // R4: a transmission only begins on a launch request
  assert_start_on_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(launch_i));
  // R4: no early end before the final tick of the final bit
  assert_full_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(tick_q == LAST_TICK && idx_q == LAST_BIT)) |=> busy_o);
  // R5: the line bit holds steady inside one bit period
  assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && tick_q != '0) |-> $stable(line_o));
endmodule

// File: rtl/loop_burst_seq.sv
module loop_burst_seq #(
  parameter int VOICE_W       = 8,
  parameter int SIG_W         = 2,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loopback,
  input  logic               rx_bit_valid,
  input  logic               rx_bit,
  input  logic               rx_abort,
  input  logic               codec_valid,
  output logic               codec_ready,
  input  logic [VOICE_W-1:0] codec_voice,
  input  logic [SIG_W-1:0]   codec_sig,
  output logic               rx_word_valid,
  output logic [VOICE_W-1:0] rx_voice,
  output logic [SIG_W-1:0]   rx_sig,
  output logic               burst_done,
  output logic               mod_en,
  output logic               line_bit
);
  localparam int WORD_W = VOICE_W + SIG_W;

  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] tx_word;
  logic              done;
  logic              busy;
  logic              launch;

  loop_rx_deser #(.WORD_W(WORD_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid_i (rx_bit_valid),
    .bit_i       (rx_bit),
    .abort_i     (rx_abort),
    .word_o      (rx_word),
    .done_o      (done)
  );

  assign launch = done && !busy;

  loop_tx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (codec_valid),
    .in_ready   (codec_ready),
    .in_word    ({codec_voice, codec_sig}),
    .launch_i   (launch),
    .loopback_i (loopback),
    .rx_word_i  (rx_word),
    .word_o     (tx_word)
  );

  loop_tx_ser #(.WORD_W(WORD_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .word_i   (tx_word),
    .busy_o   (busy),
    .line_o   (line_bit)
  );

  assign rx_word_valid = done;
  assign burst_done    = done;
  assign rx_voice      = rx_word[WORD_W-1:SIG_W];
  assign rx_sig        = rx_word[SIG_W-1:0];
  assign mod_en        = busy;

  // R4: the reply starts right after the end of a master burst
  assert_mod_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_en) |-> $past(burst_done));
  // R5: the line rests at idle whenever the modulator is off
  assert_idle_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> !line_bit);
endmodule

// File: tb/loop_burst_seq_tb.sv
module loop_burst_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T = 4;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loopback = 1'b0;
  logic rx_bit_valid = 1'b0;
  logic rx_bit = 1'b0;
  logic rx_abort = 1'b0;
  logic codec_valid = 1'b0;
  logic codec_ready;
  logic [7:0] codec_voice = '0;
  logic [1:0] codec_sig = '0;
  logic rx_word_valid;
  logic [7:0] rx_voice;
  logic [1:0] rx_sig;
  logic burst_done, mod_en, line_bit;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_burst_seq #(.VOICE_W(8), .SIG_W(2), .TICKS_PER_BIT(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .loopback(loopback),
    .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit), .rx_abort(rx_abort),
    .codec_valid(codec_valid), .codec_ready(codec_ready),
    .codec_voice(codec_voice), .codec_sig(codec_sig),
    .rx_word_valid(rx_word_valid), .rx_voice(rx_voice), .rx_sig(rx_sig),
    .burst_done(burst_done), .mod_en(mod_en), .line_bit(line_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [9:0] w, input int nbits, input bit abort_last);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      rx_bit_valid = 1'b1;
      rx_bit = w[9-i];
      rx_abort = abort_last && (i == nbits - 1);
      @(negedge clk);
      rx_bit_valid = 1'b0;
      rx_abort = 1'b0;
    end
  endtask

  task automatic load_codec(input logic [9:0] w);
    @(negedge clk);
    codec_valid = 1'b1;
    codec_voice = w[9:2];
    codec_sig = w[1:0];
    @(negedge clk);
    codec_valid = 1'b0;
  endtask

  task automatic quiet_window(input string req);
    int seen = 0;
    for (int c = 0; c < 3 * N * T; c++) begin
      @(negedge clk);
      if (burst_done || rx_word_valid || mod_en) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic exchange(input logic [9:0] rxw, input logic [9:0] txw);
    int en_miss = 0;
    int bit_miss = 0;
    send_bits(rxw, N, 1'b0);
    chk(burst_done && rx_word_valid, "R2 strobe", {burst_done, rx_word_valid}, 3);
    chk({rx_voice, rx_sig} == rxw, "R2 word", {rx_voice, rx_sig}, rxw);
    for (int c = 0; c < N * T; c++) begin
      @(negedge clk);
      if (c == 0) chk(!burst_done, "R2 pulse width", burst_done, 0);
      if (!mod_en) en_miss++;
      if (line_bit !== txw[9 - c / T]) bit_miss++;
    end
    chk(en_miss == 0, "R4 enable length", en_miss, 0);
    chk(bit_miss == 0, "R5 serial order", bit_miss, 0);
    @(negedge clk);
    chk(!mod_en && !line_bit, "R4 enable end", {mod_en, line_bit}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mod_en && !line_bit, "R1 line idle", {mod_en, line_bit}, 0);
    chk(!burst_done && !rx_word_valid, "R1 no strobe", {burst_done, rx_word_valid}, 0);
    chk(codec_ready, "R1 ready", codec_ready, 1);

    // R2 R5 R6: every received word, each with its own codec reply
    for (int p = 0; p < 1024; p++) begin
      logic [9:0] cw;
      cw = 10'(p) ^ 10'h35A;
      load_codec(cw);
      chk(!codec_ready, "R6 held", codec_ready, 0);
      exchange(10'(p), cw);
      chk(codec_ready, "R6 released", codec_ready, 1);
    end

    // R7 empty stage replies with zeros
    exchange(10'h3C3, 10'h000);

    // R6 back-pressure: second offer refused, first word sent
    load_codec(10'h2B1);
    load_codec(10'h14E);
    exchange(10'h0F0, 10'h2B1);
    exchange(10'h0F1, 10'h000);

    // R8 loopback echoes the received word and keeps the codec word
    for (int k = 0; k < 64; k++) begin
      logic [9:0] cw, rw;
      cw = 10'(k * 13 + 5);
      rw = 10'(k * 16 + 9) ^ 10'h2AA;
      load_codec(cw);
      loopback = 1'b1;
      exchange(rw, rw);
      chk(!codec_ready, "R8 codec word kept", codec_ready, 0);
      loopback = 1'b0;
      exchange(~rw, cw);
    end

    // R3 abort after five bits, then a clean burst
    send_bits(10'h3FF, 5, 1'b0);
    @(negedge clk); rx_abort = 1'b1;
    @(negedge clk); rx_abort = 1'b0;
    quiet_window("R3 partial dropped");
    load_codec(10'h155);
    exchange(10'h2A6, 10'h155);

    // R3 abort together with the tenth bit
    send_bits(10'h1E7, N, 1'b1);
    chk(!burst_done, "R3 tenth bit aborted", burst_done, 0);
    quiet_window("R3 no reply");
    exchange(10'h081, 10'h000);

    // R3 nine bits, abort, then a full burst must not merge with them
    send_bits(10'h3FF, 9, 1'b0);
    @(negedge clk); rx_abort = 1'b1;
    @(negedge clk); rx_abort = 1'b0;
    exchange(10'h000, 10'h000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule